// File: doc/BRIEF.md
# Debug Burst Read Engine

This block is the read half of the memory-bus module inside a JTAG debug unit. The host shifts a 53-bit command into the block, least significant bit first, while the TAP is in shift-DR, and then pulses update. A read command names a start address, a word count and a word size. The engine then fetches words from the memory bus through a simple request/acknowledge/error handshake and keeps one word buffered ahead of the serializer.

During the following shift-DR, the host receives a stream of status bits for each word. Each status bit is 0 while no word is ready, and 1 once a word is ready. The word itself follows the 1, least significant bit first. After the final word the engine shifts out a 32-bit reflected CRC of every data bit it sent. The CRC lets the host confirm that the transfer was clean.

A failing bus cycle is recorded in an error register together with its address. After that failure the engine makes no further bus cycles, but the rest of the burst keeps its framing so that the host does not lose its place. The host clears the error register with a dedicated command.

Top module: `dbgrd_burst_read`

## Requirements
- R1: A command is the 53 bits last shifted in on `tdi` (first bit becomes bit 0), taken at an `updateEn` pulse. Bits 15:0 hold the count, bits 47:16 the address, bits 51:48 the opcode, and bit 52 must be 0. A command with bit 52 set is ignored.
- R2: Opcode 1 reads bytes, opcode 2 reads halfwords and opcode 3 reads 32-bit words. `busSize` is 0, 1 or 2 respectively. Bus addresses start at the command address and step by 1, 2 or 4. `busRdata` is right-justified. Once raised, a request holds with a stable address until `busAck` or `busErr` arrives.
- R3: While `shiftEn` is high in a burst, `tdo` gives 0 for each shift cycle in which no word is ready, then a single 1. The word follows, LSB first, as 8, 16 or 32 bits.
- R4: The fetch of the next word starts on the cycle the current word leaves the buffer. With a bus that answers in one cycle, every word after the first shows a 1 on its first status bit.
- R5: The CRC starts at all ones. For each data bit, LSB first, the CRC shifts right by one place and XORs in 0xEDB88320 when that bit differs from the CRC's bit 0.
- R6: After the last data bit, the 32 CRC bits follow LSB first with no final inversion. `tdo` is 0 after that.
- R7: On `busErr`, `errStatus[0]` is set and `errStatus[32:1]` takes the failing address. While bit 0 is already set, later errors leave the register unchanged.
- R8: Opcode 0xA with command bit 0 equal to 1 clears `errStatus`. With command bit 0 equal to 0 it has no effect.
- R9: After a bus error, the burst makes no further bus requests. The failing word and every word after it go out as zeros with normal status framing, and these zeros are included in the CRC.
- R10: A read command with a count of 0 is ignored. It produces no bus request, and `tdo` stays 0.
- R11: An `updateEn` pulse during a burst that carries no valid read command ends the burst. After the pulse `tdo` stays 0 and no bus request is made.
- R12: After reset, `tdo`, `busReq` and `errStatus` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one TCK per cycle) |
| rst_n | input | 1 | Active-low reset |
| shiftEn | input | 1 | Shift-DR cycle: take `tdi`, advance `tdo` |
| updateEn | input | 1 | Update-DR pulse: act on the shifted command |
| tdi | input | 1 | Serial command bit |
| tdo | output | 1 | Serial status, data or CRC bit |
| busReq | output | 1 | Bus read request |
| busAddr | output | 32 | Bus read address |
| busSize | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| busAck | input | 1 | Bus read completed |
| busErr | input | 1 | Bus read failed |
| busRdata | input | 32 | Right-justified read data |
| errStatus | output | 33 | Bit 0 error flag, bits 32:1 failing address |

## Verification
The hardest situation to bring about is a bus error in the middle of a burst. It has to be followed by zero-filled words whose framing and CRC stay correct, and then by a second error that must not overwrite the first one. The bench bus model fails exactly one chosen address. The bench then checks the zero data, the CRC over those zeros, the number of bus responses and the stored address. A second burst then fails at a different address while the flag is still set. The prefetch timing appears only with a bus that answers in one cycle, so directed bursts run at zero extra latency and count the status polls for each word.

// File: rtl/dbgrd_pkg.sv
package dbgrd_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_RD_BYTE = 4'h1;
  localparam logic [OP_W-1:0] OP_RD_HALF = 4'h2;
  localparam logic [OP_W-1:0] OP_RD_WORD = 4'h3;
  localparam logic [OP_W-1:0] OP_ERR_WR  = 4'hA;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } wsize_e;

  typedef enum logic [1:0] {
    TDO_ZERO,
    TDO_ONE,
    TDO_DATA,
    TDO_CRC
  } tdosel_e;

  typedef struct packed {
    tdosel_e tdoSel;
    logic    startBurst;
    logic    takeWord;
    logic    fillZero;
    logic    moveBuf;
    logic    shiftData;
    logic    shiftCrc;
    logic    logErr;
    logic    clearErr;
  } strobes_t;

endpackage

// File: rtl/dbgrd_ctrl.sv
module dbgrd_ctrl
  import dbgrd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shiftEn,
  input  logic                updateEn,
  input  logic [OP_W-1:0]     cmdOp,
  input  logic [CNT_W-1:0]    cmdCount,
  input  logic                cmdTop,
  input  logic                busAck,
  input  logic                busErr,
  output logic                busReq,
  output wsize_e              curSize,
  output strobes_t            stb
);

  localparam int BIT_W = 6;
  localparam logic [BIT_W-1:0] CRC_LAST = BIT_W'(31);

  typedef enum logic [1:0] {P_IDLE, P_STAT, P_DATA, P_CRC} phase_e;

  phase_e            phaseQ;
  wsize_e            sizeQ;
  logic [CNT_W-1:0]  sendLeft;
  logic [CNT_W-1:0]  fetchLeft;
  logic [BIT_W-1:0]  bitCnt;
  logic              bufValid;
  logic              halted;

  logic              isRead;
  logic              startOk;
  logic              doShift;
  logic              fetchHit;
  logic              fetchBad;
  logic              zeroFill;
  logic [BIT_W-1:0]  lastDataBit;
  wsize_e            opSize;

  always_comb begin
    case (sizeQ)
      SZ_BYTE: lastDataBit = BIT_W'(7);
      SZ_HALF: lastDataBit = BIT_W'(15);
      default: lastDataBit = BIT_W'(31);
    endcase
  end

  always_comb begin
    case (cmdOp)
      OP_RD_BYTE: opSize = SZ_BYTE;
      OP_RD_HALF: opSize = SZ_HALF;
      default:    opSize = SZ_WORD;
    endcase
  end

  assign isRead  = !cmdTop && (cmdOp == OP_RD_BYTE || cmdOp == OP_RD_HALF || cmdOp == OP_RD_WORD);
  assign startOk = updateEn && isRead && (cmdCount != '0);
  assign doShift = shiftEn && !updateEn;

  assign busReq   = (phaseQ != P_IDLE) && !bufValid && (fetchLeft != '0) && !halted;
  assign fetchHit = busReq && busAck && !updateEn;
  assign fetchBad = busReq && !busAck && busErr && !updateEn;
  assign zeroFill = (phaseQ != P_IDLE) && halted && !bufValid && (fetchLeft != '0) && !updateEn;

  assign curSize = sizeQ;

  always_comb begin
    stb            = '0;
    stb.tdoSel     = TDO_ZERO;
    stb.startBurst = startOk;
    stb.clearErr   = updateEn && !cmdTop && (cmdOp == OP_ERR_WR) && cmdCount[0];
    stb.takeWord   = fetchHit;
    stb.fillZero   = fetchBad || zeroFill;
    stb.logErr     = fetchBad;
    case (phaseQ)
      P_STAT: begin
        stb.tdoSel  = bufValid ? TDO_ONE : TDO_ZERO;
        stb.moveBuf = doShift && bufValid;
      end
      P_DATA: begin
        stb.tdoSel    = TDO_DATA;
        stb.shiftData = doShift;
      end
      P_CRC: begin
        stb.tdoSel   = TDO_CRC;
        stb.shiftCrc = doShift;
      end
      default: stb.tdoSel = TDO_ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseQ    <= P_IDLE;
      sizeQ     <= SZ_WORD;
      sendLeft  <= '0;
      fetchLeft <= '0;
      bitCnt    <= '0;
      bufValid  <= 1'b0;
      halted    <= 1'b0;
    end else if (updateEn) begin
      bitCnt   <= '0;
      bufValid <= 1'b0;
      halted   <= 1'b0;
      if (startOk) begin
        phaseQ    <= P_STAT;
        sizeQ     <= opSize;
        sendLeft  <= cmdCount;
        fetchLeft <= cmdCount;
      end else begin
        phaseQ    <= P_IDLE;
        sendLeft  <= '0;
        fetchLeft <= '0;
      end
    end else begin
      if (stb.takeWord || stb.fillZero) begin
        bufValid  <= 1'b1;
        fetchLeft <= fetchLeft - 1'b1;
      end else if (stb.moveBuf) begin
        bufValid <= 1'b0;
      end
      if (fetchBad) halted <= 1'b1;

      if (doShift) begin
        case (phaseQ)
          P_STAT: begin
            if (bufValid) begin
              phaseQ <= P_DATA;
              bitCnt <= '0;
            end
          end
          P_DATA: begin
            if (bitCnt == lastDataBit) begin
              bitCnt   <= '0;
              sendLeft <= sendLeft - 1'b1;
              phaseQ   <= (sendLeft == CNT_W'(1)) ? P_CRC : P_STAT;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          P_CRC: begin
            if (bitCnt == CRC_LAST) begin
              bitCnt <= '0;
              phaseQ <= P_IDLE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dbgrd_datapath.sv
module dbgrd_datapath
  import dbgrd_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          CNT_W    = 16,
  parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shiftEn,
  input  logic                tdi,
  input  strobes_t            stb,
  input  wsize_e              curSize,
  input  logic [31:0]         busRdata,
  output logic [OP_W-1:0]     cmdOp,
  output logic [CNT_W-1:0]    cmdCount,
  output logic                cmdTop,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                tdo,
  output logic [ADDR_W:0]     errStatus
);

  localparam int CMD_W    = CNT_W + ADDR_W + OP_W + 1;
  localparam int ADDR_LSB = CNT_W;
  localparam int OP_LSB   = CNT_W + ADDR_W;

  logic [CMD_W-1:0]  cmdSr;
  logic [ADDR_W-1:0] cmdAddr;
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrStep;
  logic [31:0]       bufQ;
  logic [31:0]       rdMasked;
  logic [31:0]       outSr;
  logic [31:0]       crcQ;
  logic [31:0]       crcNext;
  logic [ADDR_W:0]   errQ;

  assign cmdCount = cmdSr[CNT_W-1:0];
  assign cmdAddr  = cmdSr[ADDR_LSB +: ADDR_W];
  assign cmdOp    = cmdSr[OP_LSB +: OP_W];
  assign cmdTop   = cmdSr[CMD_W-1];

  always_comb begin
    case (curSize)
      SZ_BYTE: begin addrStep = ADDR_W'(1); rdMasked = {24'h0, busRdata[7:0]};  end
      SZ_HALF: begin addrStep = ADDR_W'(2); rdMasked = {16'h0, busRdata[15:0]}; end
      default: begin addrStep = ADDR_W'(4); rdMasked = busRdata;                end
    endcase
  end

  assign crcNext = (crcQ >> 1) ^ ((outSr[0] ^ crcQ[0]) ? CRC_POLY : 32'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdSr <= '0;
      addrQ <= '0;
      bufQ  <= '0;
      outSr <= '0;
      crcQ  <= '0;
      errQ  <= '0;
    end else begin
      if (shiftEn) cmdSr <= {tdi, cmdSr[CMD_W-1:1]};

      if (stb.startBurst)    addrQ <= cmdAddr;
      else if (stb.takeWord) addrQ <= addrQ + addrStep;

      if (stb.takeWord)      bufQ <= rdMasked;
      else if (stb.fillZero) bufQ <= '0;

      if (stb.moveBuf)        outSr <= bufQ;
      else if (stb.shiftData) outSr <= outSr >> 1;

      if (stb.startBurst)     crcQ <= '1;
      else if (stb.shiftData) crcQ <= crcNext;
      else if (stb.shiftCrc)  crcQ <= crcQ >> 1;

      if (stb.clearErr)                errQ <= '0;
      else if (stb.logErr && !errQ[0]) errQ <= {addrQ, 1'b1};
    end
  end

  always_comb begin
    case (stb.tdoSel)
      TDO_ONE:  tdo = 1'b1;
      TDO_DATA: tdo = outSr[0];
      TDO_CRC:  tdo = crcQ[0];
      default:  tdo = 1'b0;
    endcase
  end

  assign busAddr   = addrQ;
  assign errStatus = errQ;

endmodule

// File: rtl/dbgrd_burst_read.sv
module dbgrd_burst_read
  import dbgrd_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          CNT_W    = 16,
  parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shiftEn,
  input  logic              updateEn,
  input  logic              tdi,
  output logic              tdo,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  input  logic              busAck,
  input  logic              busErr,
  input  logic [31:0]       busRdata,
  output logic [ADDR_W:0]   errStatus
);

  strobes_t         stb;
  wsize_e           curSize;
  logic [OP_W-1:0]  cmdOp;
  logic [CNT_W-1:0] cmdCount;
  logic             cmdTop;

  dbgrd_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shiftEn  (shiftEn),
    .updateEn (updateEn),
    .cmdOp    (cmdOp),
    .cmdCount (cmdCount),
    .cmdTop   (cmdTop),
    .busAck   (busAck),
    .busErr   (busErr),
    .busReq   (busReq),
    .curSize  (curSize),
    .stb      (stb)
  );

  dbgrd_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CRC_POLY(CRC_POLY)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .shiftEn   (shiftEn),
    .tdi       (tdi),
    .stb       (stb),
    .curSize   (curSize),
    .busRdata  (busRdata),
    .cmdOp     (cmdOp),
    .cmdCount  (cmdCount),
    .cmdTop    (cmdTop),
    .busAddr   (busAddr),
    .tdo       (tdo),
    .errStatus (errStatus)
  );

  assign busSize = curSize;

endmodule

// File: rtl/dbgrd_checker.sv
module dbgrd_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              updateEn,
  input logic              busReq,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busAck,
  input logic              busErr,
  input logic [ADDR_W:0]   errStatus
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busReq && !busAck && !busErr && !updateEn |=> busReq && $stable(busAddr)); // R2

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    errStatus[0] && !updateEn |=> $stable(errStatus)); // R7

  AST_ERR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    busReq && busErr && !busAck && !updateEn && !errStatus[0]
      |=> errStatus == {$past(busAddr), 1'b1}); // R7

  AST_HALT_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    busReq && busErr && !busAck && !updateEn |=> !busReq); // R9

  AST_CLEAR_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(errStatus[0]) |-> $past(updateEn)); // R8

endmodule

bind dbgrd_burst_read dbgrd_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .updateEn  (updateEn),
  .busReq    (busReq),
  .busAddr   (busAddr),
  .busAck    (busAck),
  .busErr    (busErr),
  .errStatus (errStatus)
);

// File: tb/dbgrd_burst_read_tb_top.sv
module dbgrd_burst_read_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shiftEn = 1'b0;
  logic        updateEn = 1'b0;
  logic        tdi = 1'b0;
  logic        tdo;
  logic        busReq;
  logic [31:0] busAddr;
  logic [1:0]  busSize;
  logic        busAck = 1'b0;
  logic        busErr = 1'b0;
  logic [31:0] busRdata = '0;
  logic [32:0] errStatus;

  int checks = 0;
  int errors = 0;

  int          busLat = 0;
  int          waitCnt = 0;
  int          respCnt = 0;
  logic        errEn = 1'b0;
  logic [31:0] errAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgrd_burst_read dut_i (
    .clk(clk), .rst_n(rst_n), .shiftEn(shiftEn), .updateEn(updateEn), .tdi(tdi),
    .tdo(tdo), .busReq(busReq), .busAddr(busAddr), .busSize(busSize),
    .busAck(busAck), .busErr(busErr), .busRdata(busRdata), .errStatus(errStatus)
  );

  function automatic logic [31:0] memVal(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hC3A55A3C;
  endfunction

  function automatic logic [31:0] sizeMask(input int sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFFFFFF;
  endfunction

  function automatic logic [31:0] crcUpd(input logic [31:0] c, input logic [31:0] d, input int nb);
    logic [31:0] r = c;
    for (int i = 0; i < nb; i++) begin
      logic fb = d[i] ^ r[0];
      r = (r >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
    end
    return r;
  endfunction

  // bus model: responds at negedge, held until the next negedge
  always @(negedge clk) begin
    busAck = 1'b0;
    busErr = 1'b0;
    if (rst_n && busReq) begin
      if (waitCnt >= busLat) begin
        waitCnt = 0;
        respCnt++;
        if (errEn && busAddr == errAddr) busErr = 1'b1;
        else begin
          busAck   = 1'b1;
          busRdata = memVal(busAddr) & sizeMask(int'(busSize));
        end
      end else waitCnt++;
    end else waitCnt = 0;
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic top, input logic [3:0] op, input logic [31:0] addr, input logic [15:0] cnt);
    logic [52:0] cmd = {top, op, addr, cnt};
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      shiftEn = 1'b1;
      tdi = cmd[i];
    end
    @(negedge clk);
    shiftEn = 1'b0;
    tdi = 1'b0;
    updateEn = 1'b1;
    @(negedge clk);
    updateEn = 1'b0;
  endtask

  // runs a full read burst and checks framing, data and CRC
  task automatic readBurst(input int sz, input int cnt, input logic [31:0] addr, input int errIdx, input bit fastBus);
    int nb = 8 << sz;
    int step = 1 << sz;
    logic [31:0] crcExp = 32'hFFFFFFFF;
    logic [31:0] got;
    logic [31:0] crcGot;
    int respStart = respCnt;
    sendCmd(1'b0, 4'(sz + 1), addr, 16'(cnt));
    for (int w = 0; w < cnt; w++) begin
      logic [31:0] exp;
      int polls = 0;
      logic b = 1'b0;
      exp = (errIdx >= 0 && w >= errIdx) ? 32'h0 : (memVal(addr + 32'(w * step)) & sizeMask(sz));
      while (!b && polls < 100) begin
        @(negedge clk);
        shiftEn = 1'b1;
        b = tdo;
        polls++;
      end
      check(b, "R3 status bit", 64'(b), 64'd1);
      if (fastBus && w > 0) check(polls == 1, "R4 prefetch polls", 64'(polls), 64'd1);
      got = '0;
      for (int k = 0; k < nb; k++) begin
        @(negedge clk);
        got[k] = tdo;
      end
      if (errIdx >= 0 && w >= errIdx) check(got == exp, "R9 zero fill", 64'(got), 64'(exp));
      else check(got == exp, "R2 R3 data word", 64'(got), 64'(exp));
      crcExp = crcUpd(crcExp, exp, nb);
    end
    crcGot = '0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      crcGot[k] = tdo;
    end
    check(crcGot == crcExp, "R5 R6 crc", 64'(crcGot), 64'(crcExp));
    @(negedge clk);
    check(tdo == 1'b0, "R6 idle after crc", 64'(tdo), 64'd0);
    shiftEn = 1'b0;
    if (errIdx >= 0)
      check(respCnt - respStart == errIdx + 1, "R9 bus cycles", 64'(respCnt - respStart), 64'(errIdx + 1));
    else
      check(respCnt - respStart == cnt, "R2 bus cycles", 64'(respCnt - respStart), 64'(cnt));
  endtask

  task automatic quietShift(input int n, input string req);
    int r0 = respCnt;
    logic anyOne = 1'b0;
    logic anyReq = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      shiftEn = 1'b1;
      anyOne |= tdo;
      anyReq |= busReq;
    end
    @(negedge clk);
    shiftEn = 1'b0;
    check(!anyOne, req, 64'(anyOne), 64'd0);
    check(!anyReq && respCnt == r0, req, 64'(respCnt - r0), 64'd0);
  endtask

  task automatic runTests();
    void'($urandom(32'd7531));
    repeat (3) @(negedge clk);
    check(tdo == 1'b0 && busReq == 1'b0 && errStatus == '0, "R12 reset state",
          64'({tdo, busReq, errStatus}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    busLat = 0; readBurst(2, 3, 32'h1000, -1, 1'b1);
    busLat = 0; readBurst(0, 5, 32'h0103, -1, 1'b1);
    busLat = 2; readBurst(0, 4, 32'h0200, -1, 1'b0);
    busLat = 1; readBurst(1, 4, 32'h0402, -1, 1'b0);
    busLat = 0; readBurst(1, 3, 32'h0800, -1, 1'b1);

    // R10: zero count
    sendCmd(1'b0, 4'h3, 32'h5000, 16'd0);
    quietShift(40, "R10 zero count ignored");

    // R1: bit 52 set
    sendCmd(1'b1, 4'h3, 32'h5000, 16'd2);
    quietShift(40, "R1 top bit set ignored");

    // R7 R9: bus error in the middle of a burst
    errEn = 1'b1; errAddr = 32'h2008; busLat = 1;
    readBurst(2, 5, 32'h2000, 2, 1'b0);
    check(errStatus == {32'h2008, 1'b1}, "R7 error capture", 64'(errStatus), 64'({32'h2008, 1'b1}));

    // R7 sticky: second error keeps the first record
    errAddr = 32'h3002; busLat = 0;
    readBurst(1, 3, 32'h3000, 1, 1'b0);
    check(errStatus == {32'h2008, 1'b1}, "R7 first error kept", 64'(errStatus), 64'({32'h2008, 1'b1}));
    errEn = 1'b0;

    // R8: clear with data bit 0 then 1
    sendCmd(1'b0, 4'hA, 32'h0, 16'd0);
    @(negedge clk);
    check(errStatus == {32'h2008, 1'b1}, "R8 clear with 0 no effect", 64'(errStatus), 64'({32'h2008, 1'b1}));
    sendCmd(1'b0, 4'hA, 32'h0, 16'd1);
    @(negedge clk);
    check(errStatus == '0, "R8 clear with 1", 64'(errStatus), 64'd0);

    // R11: abort after first word of a four-word burst
    busLat = 0;
    sendCmd(1'b0, 4'h3, 32'h6000, 16'd4);
    begin
      logic b = 1'b0;
      int polls = 0;
      logic [31:0] got = '0;
      while (!b && polls < 100) begin
        @(negedge clk); shiftEn = 1'b1; b = tdo; polls++;
      end
      for (int k = 0; k < 32; k++) begin
        @(negedge clk); got[k] = tdo;
      end
      check(got == memVal(32'h6000), "R11 word before abort", 64'(got), 64'(memVal(32'h6000)));
      @(negedge clk);
      shiftEn = 1'b0; updateEn = 1'b1;
      @(negedge clk);
      updateEn = 1'b0;
    end
    quietShift(60, "R11 abort quiet");

    // random bursts
    for (int n = 0; n < 10; n++) begin
      int sz = int'($urandom_range(2, 0));
      int cnt = int'($urandom_range(6, 1));
      logic [31:0] a = $urandom() & ~((32'd1 << sz) - 32'd1);
      busLat = int'($urandom_range(3, 0));
      readBurst(sz, cnt, a, -1, busLat == 0);
    end
  endtask

  initial begin
    fork
      runTests();
      begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule